// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block turns word-wide requests from a simple valid/ready bus into the configuration state and control strobes that an interrupt arbiter needs. It sorts each address into one of four windows: a priority word for each source, read-only packed pending words, enable words for each target context, and a two-register block for each context holding its threshold and its claim/complete port. The configuration state is held here and driven out in flat vectors, so the arbiter sees every change in the cycle after the write.

Reading a context's claim/complete register sends a claim strobe to the arbiter. The source ID that the arbiter returns in the same cycle becomes the read data. Writing that register sends a completion strobe carrying the written ID. Each request gets exactly one registered response, which is held while the requester stalls. Window base addresses and strides are elaboration parameters. The enable and context strides must be powers of two.

Top module: `irq_regfile`

## Requirements
- R1: A request takes effect only if req_addr[1:0] is 0 and req_be is 4'hF. Any other request changes no state, raises no strobe and no error, and reads as 0.
- R2: The priority window at PRIO_BASE has one word per source. Word k holds the priority of source k+1. A write keeps only the low PRIO_W bits (3 by default), which read back and appear at prio_o[s*PRIO_W +: PRIO_W] for source s.
- R3: The pending window at PEND_BASE returns word w as pend_i bits 32w upward, zero-padded above the source count. Writes to it have no effect.
- R4: In the enable window, the context is the offset divided by EN_STRIDE and the word is bits [log2(EN_STRIDE)-1:2] of the offset. A word index at or beyond the word count is ignored: it reads 0 and raises no error. Stored words appear at en_o[(c*NUM_WORDS+w)*32 +: 32].
- R5: Offset 0 of a context block (context = offset / CTX_STRIDE) is its threshold, shown at thr_o[c*PRIO_W +: PRIO_W]. A write whose value exceeds MAX_PRIO is dropped.
- R6: A read at offset 4 of a context block raises claim_o with claim_ctx_o for one cycle at the handshake and returns claim_id_i as read data.
- R7: A claim happens exactly once for each handshake. While req_valid is held with req_ready low, no claim is raised.
- R8: A write at offset 4 of a context block raises cpl_o with cpl_ctx_o and cpl_id_o equal to the written ID, but only when the ID is less than NUM_SRC. A larger ID raises nothing.
- R9: An aligned full-word request outside all four windows reads 0, changes nothing, and returns rsp_err high with its response. Unused offsets inside a context block read 0 without error.
- R10: Each handshake (req_valid and req_ready) produces one response in the next cycle. While rsp_ready is low, the response holds its data and req_ready is low.
- R11: After reset there is no response, req_ready is high, and all priority, enable and threshold state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Address outside all windows |
| pend_i | input | NUM_SRC | Pending flags from the arbiter, bit s = source s |
| prio_o | output | NUM_SRC*PRIO_W | Source priorities, source 0 fixed at 0 |
| en_o | output | NUM_CTX*NUM_WORDS*32 | Enable words per context |
| thr_o | output | NUM_CTX*PRIO_W | Threshold per context |
| claim_o | output | 1 | Claim strobe |
| claim_ctx_o | output | CTX_W | Claiming context |
| claim_id_i | input | ID_W | Source ID the arbiter grants for the claim |
| cpl_o | output | 1 | Completion strobe |
| cpl_ctx_o | output | CTX_W | Completing context |
| cpl_id_o | output | ID_W | Completed source ID |

## Verification
On every cycle the assertions check that a stalled response keeps its data and error flag, that no claim is raised while a request waits for ready, that every claim is followed by a response, and that claim and completion never fire together. They also check that a completion carries an in-range ID, that an error flag only comes with a response, and that an over-range threshold write leaves the threshold alone. Only the bench scenarios can show the address arithmetic: which word each window offset reaches, that ignored indices and sub-word requests leave state untouched, and that the read data and the flat configuration outputs carry the values written.

// File: rtl/irqrf_pkg.sv
package irqrf_pkg;

   // Outcome of address decode for one request
   typedef enum logic [2:0] {
      RG_NONE  = 3'd0,  // outside every window
      RG_IGN   = 3'd1,  // inside a window but not acted on
      RG_PRIO  = 3'd2,
      RG_PEND  = 3'd3,
      RG_EN    = 3'd4,
      RG_THR   = 3'd5,
      RG_CLAIM = 3'd6
   } region_e;

endpackage

// File: rtl/irqrf_decode.sv
module irqrf_decode
   import irqrf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned NUM_SRC    = 40,
   parameter int unsigned NUM_CTX    = 2,
   parameter int unsigned PRIO_BASE  = 32'h0000_0000,
   parameter int unsigned PEND_BASE  = 32'h0000_1000,
   parameter int unsigned EN_BASE    = 32'h0000_2000,
   parameter int unsigned EN_STRIDE  = 32'h0000_0080,
   parameter int unsigned CTX_BASE   = 32'h0020_0000,
   parameter int unsigned CTX_STRIDE = 32'h0000_1000,
   localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
   localparam int unsigned ID_W      = $clog2(NUM_SRC),
   localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   output region_e           region,
   output logic [ID_W-1:0]   src,
   output logic [WORD_W-1:0] word,
   output logic [CTX_W-1:0]  ctx
);

   localparam int unsigned EN_SH     = $clog2(EN_STRIDE);
   localparam int unsigned CTX_SH    = $clog2(CTX_STRIDE);
   localparam logic [31:0] PRIO_SIZE = 32'((NUM_SRC - 1) * 4);
   localparam logic [31:0] PEND_SIZE = 32'(NUM_WORDS * 4);
   localparam logic [31:0] EN_SIZE   = 32'(NUM_CTX * EN_STRIDE);
   localparam logic [31:0] CTX_SIZE  = 32'(NUM_CTX * CTX_STRIDE);

   // Elaboration-time parameter checks
   if ((32'd1 << EN_SH) != EN_STRIDE) begin : g_chk_en_pow2
      $error("EN_STRIDE must be a power of two");
   end
   if ((32'd1 << CTX_SH) != CTX_STRIDE) begin : g_chk_ctx_pow2
      $error("CTX_STRIDE must be a power of two");
   end
   if (NUM_WORDS * 4 > EN_STRIDE) begin : g_chk_en_fit
      $error("EN_STRIDE too small for the enable words");
   end
   if (CTX_STRIDE < 8) begin : g_chk_ctx_fit
      $error("CTX_STRIDE must hold two registers");
   end

   logic [31:0] a32;
   logic [31:0] off_p, off_q, off_e, off_c;
   logic [31:0] widx, lo;

   always_comb begin
      a32    = 32'(addr);
      off_p  = a32 - PRIO_BASE;
      off_q  = a32 - PEND_BASE;
      off_e  = a32 - EN_BASE;
      off_c  = a32 - CTX_BASE;
      widx   = (off_e & (EN_STRIDE - 1)) >> 2;
      lo     = off_c & (CTX_STRIDE - 1);
      region = RG_NONE;
      src    = '0;
      word   = '0;
      ctx    = '0;
      if (addr[1:0] != 2'b00 || be != 4'hF) begin
         region = RG_IGN;
      end else if (off_p < PRIO_SIZE) begin
         region = RG_PRIO;
         src    = ID_W'((off_p >> 2) + 32'd1);
      end else if (off_q < PEND_SIZE) begin
         region = RG_PEND;
         word   = WORD_W'(off_q >> 2);
      end else if (off_e < EN_SIZE) begin
         ctx  = CTX_W'(off_e >> EN_SH);
         word = WORD_W'(widx);
         region = (widx < 32'(NUM_WORDS)) ? RG_EN : RG_IGN;
      end else if (off_c < CTX_SIZE) begin
         ctx = CTX_W'(off_c >> CTX_SH);
         if (lo == 32'd0)      region = RG_THR;
         else if (lo == 32'd4) region = RG_CLAIM;
         else                  region = RG_IGN;
      end
   end

endmodule

// File: rtl/irqrf_store.sv
module irqrf_store
   import irqrf_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 40,
   parameter int unsigned NUM_CTX  = 2,
   parameter int unsigned PRIO_W   = 3,
   parameter int unsigned MAX_PRIO = 7,
   localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
   localparam int unsigned ID_W      = $clog2(NUM_SRC),
   localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  region_e                           region,
   input  logic [ID_W-1:0]                   src,
   input  logic [WORD_W-1:0]                 word,
   input  logic [CTX_W-1:0]                  ctx,
   input  logic [31:0]                       wdata,
   output logic [31:0]                       cfg_rdata,
   output logic [NUM_SRC*PRIO_W-1:0]         prio_o,
   output logic [NUM_CTX*NUM_WORDS*32-1:0]   en_o,
   output logic [NUM_CTX*PRIO_W-1:0]         thr_o
);

   logic [PRIO_W-1:0] prio_q [NUM_SRC];
   logic [31:0]       en_q   [NUM_CTX][NUM_WORDS];
   logic [PRIO_W-1:0] thr_q  [NUM_CTX];

   logic thr_ok;
   assign thr_ok = (wdata <= 32'(MAX_PRIO));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(NUM_SRC); s++) prio_q[s] <= '0;
         for (int c = 0; c < int'(NUM_CTX); c++) begin
            thr_q[c] <= '0;
            for (int w = 0; w < int'(NUM_WORDS); w++) en_q[c][w] <= '0;
         end
      end else if (wr) begin
         for (int s = 1; s < int'(NUM_SRC); s++) begin
            if (region == RG_PRIO && int'(src) == s) prio_q[s] <= wdata[PRIO_W-1:0];
         end
         for (int c = 0; c < int'(NUM_CTX); c++) begin
            if (region == RG_THR && int'(ctx) == c && thr_ok) thr_q[c] <= wdata[PRIO_W-1:0];
            for (int w = 0; w < int'(NUM_WORDS); w++) begin
               if (region == RG_EN && int'(ctx) == c && int'(word) == w) en_q[c][w] <= wdata;
            end
         end
      end
   end

   always_comb begin
      unique case (region)
         RG_PRIO: cfg_rdata = 32'(prio_q[src]);
         RG_EN:   cfg_rdata = en_q[ctx][word];
         RG_THR:  cfg_rdata = 32'(thr_q[ctx]);
         default: cfg_rdata = '0;
      endcase
   end

   // Flatten state for the arbiter
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio_out
      assign prio_o[s*PRIO_W +: PRIO_W] = prio_q[s];
   end
   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_out
      assign thr_o[c*PRIO_W +: PRIO_W] = thr_q[c];
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_en_out
         assign en_o[(c*NUM_WORDS+w)*32 +: 32] = en_q[c][w];
      end
      AST_THR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && region == RG_THR && int'(ctx) == c && wdata > 32'(MAX_PRIO)) |=> $stable(thr_q[c])); // R5
   end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irqrf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned NUM_SRC    = 40,
   parameter int unsigned NUM_CTX    = 2,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned MAX_PRIO   = 7,
   parameter int unsigned PRIO_BASE  = 32'h0000_0000,
   parameter int unsigned PEND_BASE  = 32'h0000_1000,
   parameter int unsigned EN_BASE    = 32'h0000_2000,
   parameter int unsigned EN_STRIDE  = 32'h0000_0080,
   parameter int unsigned CTX_BASE   = 32'h0020_0000,
   parameter int unsigned CTX_STRIDE = 32'h0000_1000,
   localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
   localparam int unsigned ID_W      = $clog2(NUM_SRC),
   localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_write,
   input  logic [ADDR_W-1:0]               req_addr,
   input  logic [3:0]                      req_be,
   input  logic [31:0]                     req_wdata,
   output logic                            rsp_valid,
   input  logic                            rsp_ready,
   output logic [31:0]                     rsp_rdata,
   output logic                            rsp_err,
   input  logic [NUM_SRC-1:0]              pend_i,
   output logic [NUM_SRC*PRIO_W-1:0]       prio_o,
   output logic [NUM_CTX*NUM_WORDS*32-1:0] en_o,
   output logic [NUM_CTX*PRIO_W-1:0]       thr_o,
   output logic                            claim_o,
   output logic [CTX_W-1:0]                claim_ctx_o,
   input  logic [ID_W-1:0]                 claim_id_i,
   output logic                            cpl_o,
   output logic [CTX_W-1:0]                cpl_ctx_o,
   output logic [ID_W-1:0]                 cpl_id_o
);

   localparam int unsigned WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int unsigned PEND_W = NUM_WORDS * 32;

   if (NUM_SRC < 2) begin : g_chk_src
      $error("NUM_SRC must be at least 2");
   end
   if (MAX_PRIO >= (32'd1 << PRIO_W)) begin : g_chk_prio
      $error("MAX_PRIO does not fit in PRIO_W bits");
   end
   if (ADDR_W > 32 || ADDR_W < 3) begin : g_chk_addr
      $error("ADDR_W out of range");
   end

   region_e           dec_region;
   logic [ID_W-1:0]   dec_src;
   logic [WORD_W-1:0] dec_word;
   logic [CTX_W-1:0]  dec_ctx;
   logic [31:0]       cfg_rdata;
   logic [31:0]       rd_mux;
   logic [PEND_W-1:0] pend_pad;
   logic              hs;

   irqrf_decode #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
      .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
      .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
      .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
   ) u_dec (
      .addr(req_addr), .be(req_be),
      .region(dec_region), .src(dec_src), .word(dec_word), .ctx(dec_ctx)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign hs        = req_valid && req_ready;

   irqrf_store #(
      .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr(hs && req_write), .region(dec_region),
      .src(dec_src), .word(dec_word), .ctx(dec_ctx), .wdata(req_wdata),
      .cfg_rdata(cfg_rdata), .prio_o(prio_o), .en_o(en_o), .thr_o(thr_o)
   );

   assign pend_pad = PEND_W'(pend_i);

   always_comb begin
      unique case (dec_region)
         RG_PRIO, RG_EN, RG_THR: rd_mux = cfg_rdata;
         RG_PEND:                rd_mux = pend_pad[32*int'(dec_word) +: 32];
         RG_CLAIM:               rd_mux = 32'(claim_id_i);
         default:                rd_mux = '0;
      endcase
   end

   // Strobes to the arbiter, one per handshake
   assign claim_o     = hs && !req_write && dec_region == RG_CLAIM;
   assign claim_ctx_o = dec_ctx;
   assign cpl_o       = hs && req_write && dec_region == RG_CLAIM && (req_wdata < 32'(NUM_SRC));
   assign cpl_ctx_o   = dec_ctx;
   assign cpl_id_o    = req_wdata[ID_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else if (hs) begin
         rsp_valid <= 1'b1;
         rsp_rdata <= req_write ? 32'd0 : rd_mux;
         rsp_err   <= (dec_region == RG_NONE);
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
      end
   end

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10
   AST_NO_STALL_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |-> !claim_o); // R7
   AST_CLAIM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      claim_o |=> rsp_valid); // R6
   AST_CPL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_o |-> (32'(cpl_id_o) < NUM_SRC)); // R8
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(claim_o && cpl_o)); // R8
   AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid); // R9

endmodule

// File: tb/tb_irq_regfile.sv
module tb_irq_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic [39:0] pend_i = 40'hA5_1234_5678;
   logic [119:0] prio_o;
   logic [127:0] en_o;
   logic [5:0]  thr_o;
   logic        claim_o;
   logic [0:0]  claim_ctx_o;
   logic [5:0]  claim_id_i;
   logic        cpl_o;
   logic [0:0]  cpl_ctx_o;
   logic [5:0]  cpl_id_o;

   int checks = 0;
   int errors = 0;
   int claim_cnt = 0;
   int cpl_cnt = 0;
   logic [0:0] last_claim_ctx = '0;
   logic [0:0] last_cpl_ctx = '0;
   logic [5:0] last_cpl_id = '0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_regfile dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .pend_i(pend_i), .prio_o(prio_o), .en_o(en_o), .thr_o(thr_o),
      .claim_o(claim_o), .claim_ctx_o(claim_ctx_o), .claim_id_i(claim_id_i),
      .cpl_o(cpl_o), .cpl_ctx_o(cpl_ctx_o), .cpl_id_o(cpl_id_o)
   );

   // Behavioural arbiter stub: fixed grant per context
   assign claim_id_i = (claim_ctx_o == 1'b1) ? 6'd23 : 6'd17;

   always @(posedge clk) begin
      if (claim_o) begin claim_cnt++; last_claim_ctx = claim_ctx_o; end
      if (cpl_o) begin cpl_cnt++; last_cpl_id = cpl_id_o; last_cpl_ctx = cpl_ctx_o; end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic we, input logic [3:0] be, input logic [23:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output logic er);
      @(negedge clk);
      req_valid = 1'b1; req_write = we; req_be = be; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 response present", 32'(rsp_valid), 32'd1);
      rd = rsp_rdata;
      er = rsp_err;
   endtask

   // {we, be, addr, wdata, expected rdata, expected err}
   localparam int NV = 31;
   localparam logic [93:0] VECS [NV] = '{
      {1'b1, 4'hF, 24'h000000, 32'hFFFF_FFFD, 32'h0, 1'b0},          // R2 keep low bits
      {1'b0, 4'hF, 24'h000000, 32'h0, 32'h5, 1'b0},                  // R2
      {1'b1, 4'hF, 24'h000098, 32'h3, 32'h0, 1'b0},                  // R2 last source
      {1'b0, 4'hF, 24'h000098, 32'h0, 32'h3, 1'b0},                  // R2
      {1'b0, 4'hF, 24'h000004, 32'h0, 32'h0, 1'b0},                  // R2 untouched
      {1'b1, 4'h3, 24'h000004, 32'h7, 32'h0, 1'b0},                  // R1 sub-word write
      {1'b0, 4'hF, 24'h000004, 32'h0, 32'h0, 1'b0},                  // R1
      {1'b1, 4'hF, 24'h000006, 32'h7, 32'h0, 1'b0},                  // R1 unaligned write
      {1'b0, 4'hF, 24'h000006, 32'h0, 32'h0, 1'b0},                  // R1 unaligned read
      {1'b0, 4'hF, 24'h000004, 32'h0, 32'h0, 1'b0},                  // R1
      {1'b0, 4'hF, 24'h001000, 32'h0, 32'h1234_5678, 1'b0},          // R3
      {1'b0, 4'hF, 24'h001004, 32'h0, 32'h0000_00A5, 1'b0},          // R3
      {1'b1, 4'hF, 24'h001000, 32'h0, 32'h0, 1'b0},                  // R3 write dropped
      {1'b0, 4'hF, 24'h001000, 32'h0, 32'h1234_5678, 1'b0},          // R3
      {1'b1, 4'hF, 24'h002004, 32'hDEAD_BEEF, 32'h0, 1'b0},          // R4
      {1'b0, 4'hF, 24'h002004, 32'h0, 32'hDEAD_BEEF, 1'b0},          // R4
      {1'b0, 4'hF, 24'h002084, 32'h0, 32'h0, 1'b0},                  // R4 other context
      {1'b1, 4'hF, 24'h002080, 32'h0000_00F0, 32'h0, 1'b0},          // R4
      {1'b0, 4'hF, 24'h002080, 32'h0, 32'h0000_00F0, 1'b0},          // R4
      {1'b1, 4'hF, 24'h002008, 32'h1, 32'h0, 1'b0},                  // R4 index beyond words
      {1'b0, 4'hF, 24'h002008, 32'h0, 32'h0, 1'b0},                  // R4
      {1'b1, 4'hF, 24'h200000, 32'h7, 32'h0, 1'b0},                  // R5 max accepted
      {1'b1, 4'hF, 24'h200000, 32'h8, 32'h0, 1'b0},                  // R5 over max dropped
      {1'b0, 4'hF, 24'h200000, 32'h0, 32'h7, 1'b0},                  // R5
      {1'b1, 4'hF, 24'h201000, 32'h3, 32'h0, 1'b0},                  // R5 context 1
      {1'b0, 4'hF, 24'h201000, 32'h0, 32'h3, 1'b0},                  // R5
      {1'b0, 4'hF, 24'h00009C, 32'h0, 32'h0, 1'b1},                  // R9 past priority window
      {1'b1, 4'hF, 24'h001008, 32'h5, 32'h0, 1'b1},                  // R9 past pending window
      {1'b0, 4'hF, 24'h002100, 32'h0, 32'h0, 1'b1},                  // R9 past enable window
      {1'b0, 4'hF, 24'h202000, 32'h0, 32'h0, 1'b1},                  // R9 past context window
      {1'b0, 4'hF, 24'h200008, 32'h0, 32'h0, 1'b0}                   // R9 unused context offset
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        er;
      int          c0;
      int          p0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 no response", 32'(rsp_valid), 32'd0);
      check("R11 ready", 32'(req_ready), 32'd1);
      check("R11 prio_o", 32'(|prio_o), 32'd0);
      check("R11 en_o", 32'(|en_o), 32'd0);
      check("R11 thr_o", 32'(thr_o), 32'd0);

      for (int i = 0; i < NV; i++) begin
         xfer(VECS[i][93], VECS[i][92:89], VECS[i][88:65], VECS[i][64:33], rd, er);
         check($sformatf("vector %0d rdata", i), rd, VECS[i][32:1]);
         check($sformatf("vector %0d err", i), 32'(er), 32'(VECS[i][0]));
      end

      // Configuration outputs seen by the arbiter
      check("R2 prio_o source 1", 32'(prio_o[5:3]), 32'd5);
      check("R2 prio_o source 39", 32'(prio_o[119:117]), 32'd3);
      check("R1 prio_o source 2 untouched", 32'(prio_o[8:6]), 32'd0);
      check("R5 thr_o ctx0", 32'(thr_o[2:0]), 32'd7);
      check("R5 thr_o ctx1", 32'(thr_o[5:3]), 32'd3);
      check("R4 en_o ctx0 w0", en_o[31:0], 32'd0);
      check("R4 en_o ctx0 w1", en_o[63:32], 32'hDEAD_BEEF);
      check("R4 en_o ctx1 w0", en_o[95:64], 32'h0000_00F0);

      // R6: claim reads per context
      c0 = claim_cnt;
      xfer(1'b0, 4'hF, 24'h200004, 32'h0, rd, er);
      check("R6 claim id ctx0", rd, 32'd17);
      check("R6 claim count", 32'(claim_cnt), 32'(c0 + 1));
      check("R6 claim ctx0", 32'(last_claim_ctx), 32'd0);
      xfer(1'b0, 4'hF, 24'h201004, 32'h0, rd, er);
      check("R6 claim id ctx1", rd, 32'd23);
      check("R6 claim ctx1", 32'(last_claim_ctx), 32'd1);

      // R1: unaligned claim read does nothing
      c0 = claim_cnt;
      xfer(1'b0, 4'hF, 24'h200005, 32'h0, rd, er);
      check("R1 unaligned claim rdata", rd, 32'd0);
      check("R1 unaligned claim count", 32'(claim_cnt), 32'(c0));

      // R7 / R10: claim held behind a stalled response
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_write = 1'b0; req_be = 4'hF; req_addr = 24'h000000;
      @(negedge clk);
      check("R10 first response", 32'(rsp_valid), 32'd1);
      check("R10 first rdata", rsp_rdata, 32'd5);
      req_addr = 24'h200004;
      c0 = claim_cnt;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R10 ready low while stalled", 32'(req_ready), 32'd0);
         check("R10 rdata held", rsp_rdata, 32'd5);
         check("R7 no claim while stalled", 32'(claim_cnt), 32'(c0));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 single claim", 32'(claim_cnt), 32'(c0 + 1));
      check("R6 stalled claim id", rsp_rdata, 32'd17);
      @(negedge clk);
      check("R7 still single claim", 32'(claim_cnt), 32'(c0 + 1));
      check("R10 response consumed", 32'(rsp_valid), 32'd0);

      // R8: completions
      p0 = cpl_cnt;
      xfer(1'b1, 4'hF, 24'h200004, 32'd12, rd, er);
      check("R8 complete count", 32'(cpl_cnt), 32'(p0 + 1));
      check("R8 complete id", 32'(last_cpl_id), 32'd12);
      check("R8 complete ctx0", 32'(last_cpl_ctx), 32'd0);
      xfer(1'b1, 4'hF, 24'h200004, 32'd40, rd, er);
      check("R8 out-of-range dropped", 32'(cpl_cnt), 32'(p0 + 1));
      xfer(1'b1, 4'hF, 24'h201004, 32'd39, rd, er);
      check("R8 last id accepted", 32'(cpl_cnt), 32'(p0 + 2));
      check("R8 last id value", 32'(last_cpl_id), 32'd39);
      check("R8 complete ctx1", 32'(last_cpl_ctx), 32'd1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule